// File: doc/BRIEF.md
# DMA Channel Suspend and Termination Controller

This block governs one DMA channel made of a source side and a destination side. The source side accepts read beats into a 12-entry channel buffer of 64-bit beats, which is 96 bytes in total. The destination side drains that buffer through a write port. A peripheral paces the source side with a request line. The peripheral or software can end the transfer at any time. The block keeps a live count of the bytes serviced and the current buffer address, and it can signal completion with an interrupt.

Three control inputs steer the channel. A suspend bit pauses the channel without losing anything. A source enable starts the channel on its rising edge and terminates the source side on its falling edge. A destination enable discards all buffered work on its falling edge. A pulse on the peripheral's done line also terminates the source side. When the source side terminates, the block still delivers every buffered beat. It then freezes the status counters and raises a one-cycle interrupt, if the interrupt is enabled, once the buffer is empty.

Top module: `dma_term_ctrl`

## Requirements
- R1: After synchronous reset, rd_ready_o, wr_valid_o, irq_o and irq_stat_o are 0, and buf_size_o and buf_addr_o are 0.
- R2: A rising edge of src_active_i loads buf_addr_o from base_addr_i and clears buf_size_o. A read beat is taken when per_req_i, rd_valid_i and rd_ready_o are all high. Each taken beat adds 8 to both status values. Beats leave on the write port in the order they were taken. At most 12 beats are buffered, and rd_ready_o stays 0 while the buffer is full.
- R3: While freeze_i is high, no read beat is taken and no new write beat is presented. A beat that is already presented may still complete. The buffered beats are kept, and once freeze_i falls they are all delivered in order.
- R4: A one-cycle pulse on per_done_i, or a falling edge of src_active_i, terminates the source side. After that, no read beat is taken, and every beat already buffered is still delivered.
- R5: After source termination, buf_size_o and buf_addr_o hold the byte count and address reached by the last taken beat.
- R6: After source termination, irq_o pulses for exactly one cycle, and only when irq_en_i is 1. The pulse comes only after the last buffered beat has been written. It never comes while data remains.
- R7: irq_stat_o is set together with the interrupt pulse. It stays set until a cycle with irq_clr_i high.
- R8: A done pulse that arrives while freeze_i is high drains the buffer and raises the interrupt without waiting for freeze_i to fall.
- R9: A falling edge of dst_active_i discards all buffered beats. wr_valid_o is 0 in the next cycle. No further read beat is taken, and no interrupt follows.
- R10: A presented write beat keeps wr_valid_o high and wr_data_o stable until wr_ready_i accepts it.
- R11: After any termination, a new rising edge of src_active_i, with dst_active_i high, restarts the channel with fresh status values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_active_i | input | 1 | Source enable; rise starts, fall terminates |
| dst_active_i | input | 1 | Destination enable; fall discards buffered work |
| freeze_i | input | 1 | Suspend the channel |
| irq_en_i | input | 1 | Enable the completion interrupt |
| irq_clr_i | input | 1 | Clear the sticky interrupt status |
| base_addr_i | input | 32 | Buffer start address, loaded on start |
| per_req_i | input | 1 | Peripheral transfer request |
| per_done_i | input | 1 | Peripheral termination pulse |
| rd_valid_i | input | 1 | Read beat valid |
| rd_data_i | input | 64 | Read beat data |
| rd_ready_o | output | 1 | Read beat accepted |
| wr_valid_o | output | 1 | Write beat valid |
| wr_data_o | output | 64 | Write beat data |
| wr_ready_i | input | 1 | Write beat accepted |
| buf_size_o | output | 16 | Bytes serviced since start |
| buf_addr_o | output | 32 | Current buffer address |
| irq_o | output | 1 | One-cycle completion pulse |
| irq_stat_o | output | 1 | Sticky completion status |

## Verification
A corrupted occupancy count shows up at the ports as a read port that stalls early or late, or as a completion pulse that arrives while beats are still owed to the destination. A broken pointer or output register shows up as write data out of order or repeated. The scoreboard catches either at the very next write handshake. A lost termination latch leaves rd_ready_o high, or leaves the status values moving, within one cycle of the done pulse. A missing suspend bypass after termination shows up as a drain that stalls until the suspend is released.

// File: rtl/dma_term_pkg.sv
package dma_term_pkg;
  localparam int BEAT_W_DEF = 64;
  localparam int BUF_BEATS_DEF = 12;

  typedef struct packed {
    logic start;
    logic src_stop;
    logic dst_stop;
  } chan_evt_t;
endpackage

// File: rtl/dma_beat_fifo.sv
module dma_beat_fifo #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 12,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              drain_en,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [CNT_W-1:0]  level,
  output logic              full
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  mem_cnt;
  logic              pop, load;

  assign mem_cnt = level - CNT_W'(out_valid);
  assign pop     = out_valid & out_ready;
  assign load    = drain_en & (mem_cnt != '0) & (~out_valid | out_ready);
  assign full    = (level == CNT_W'(DEPTH));

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it maps onto block RAM with a registered read
  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr] <= push_data;
    if (load) out_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      level     <= '0;
      out_valid <= 1'b0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (load) rd_ptr <= nxt(rd_ptr);
      level <= level + CNT_W'(push) - CNT_W'(pop);
      if (load) out_valid <= 1'b1;
      else if (pop) out_valid <= 1'b0;
    end
  end

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (push && !flush) |-> (level < CNT_W'(DEPTH)));
  a_r2_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |-> (level != '0));
  a_r10_hold_beat: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/dma_src_track.sv
module dma_src_track #(
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 16,
  parameter int BEAT_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              stopped,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              accept,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [SIZE_W-1:0] buf_size
);
  always_ff @(posedge clk) begin
    if (rst) begin
      buf_addr <= '0;
      buf_size <= '0;
    end else if (start) begin
      buf_addr <= base_addr;
      buf_size <= '0;
    end else if (accept) begin
      buf_addr <= buf_addr + ADDR_W'(BEAT_BYTES);
      buf_size <= buf_size + SIZE_W'(BEAT_BYTES);
    end
  end

  a_r5_status_frozen: assert property (@(posedge clk) disable iff (rst)
    (stopped && !start) |=> ($stable(buf_size) && $stable(buf_addr)));
endmodule

// File: rtl/dma_irq_gen.sv
module dma_irq_gen (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic arm,
  input  logic kill,
  input  logic empty,
  input  logic irq_en,
  input  logic irq_clr,
  output logic irq,
  output logic irq_stat
);
  logic sent, fire;

  assign fire = arm & empty & ~sent;

  always_ff @(posedge clk) begin
    if (rst) begin
      sent     <= 1'b0;
      irq      <= 1'b0;
      irq_stat <= 1'b0;
    end else begin
      irq <= fire & irq_en;
      if (start) sent <= 1'b0;
      else if (fire || kill) sent <= 1'b1;
      if (fire && irq_en) irq_stat <= 1'b1;
      else if (irq_clr) irq_stat <= 1'b0;
    end
  end

  a_r6_irq_when_empty: assert property (@(posedge clk) disable iff (rst)
    irq |-> empty);
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
endmodule

// File: rtl/dma_term_ctrl.sv
module dma_term_ctrl
  import dma_term_pkg::*;
#(
  parameter int DATA_W    = BEAT_W_DEF,
  parameter int DEPTH     = BUF_BEATS_DEF,
  parameter int ADDR_W    = 32,
  parameter int SIZE_W    = 16,
  localparam int BEAT_BYTES = DATA_W / 8,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              src_active_i,
  input  logic              dst_active_i,
  input  logic              freeze_i,
  input  logic              irq_en_i,
  input  logic              irq_clr_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic              per_req_i,
  input  logic              per_done_i,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              rd_ready_o,
  output logic              wr_valid_o,
  output logic [DATA_W-1:0] wr_data_o,
  input  logic              wr_ready_i,
  output logic [SIZE_W-1:0] buf_size_o,
  output logic [ADDR_W-1:0] buf_addr_o,
  output logic              irq_o,
  output logic              irq_stat_o
);
  chan_evt_t        evt;
  logic             src_act_q, dst_act_q, src_term_q, dst_term_q;
  logic             src_run, accept, drain_en, fifo_full;
  logic [CNT_W-1:0] level;

  assign evt.start    = src_active_i & ~src_act_q;
  assign evt.src_stop = per_done_i | (src_act_q & ~src_active_i);
  assign evt.dst_stop = dst_act_q & ~dst_active_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_act_q  <= 1'b0;
      dst_act_q  <= 1'b0;
      src_term_q <= 1'b0;
      dst_term_q <= 1'b0;
    end else begin
      src_act_q <= src_active_i;
      dst_act_q <= dst_active_i;
      if (evt.start) begin
        src_term_q <= 1'b0;
        dst_term_q <= 1'b0;
      end else begin
        if (evt.src_stop || evt.dst_stop) src_term_q <= 1'b1;
        if (evt.dst_stop) dst_term_q <= 1'b1;
      end
    end
  end

  assign src_run    = src_act_q & src_active_i & ~src_term_q & ~per_done_i;
  assign rd_ready_o = src_run & dst_active_i & ~freeze_i & ~fifo_full & per_req_i;
  assign accept     = rd_valid_i & rd_ready_o;
  // a terminated source drains regardless of suspend
  assign drain_en   = dst_active_i & ~dst_term_q & (~freeze_i | src_term_q);

  dma_beat_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .flush(evt.dst_stop),
    .push(accept), .push_data(rd_data_i),
    .drain_en(drain_en), .out_ready(wr_ready_i),
    .out_valid(wr_valid_o), .out_data(wr_data_o),
    .level(level), .full(fifo_full)
  );

  dma_src_track #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .BEAT_BYTES(BEAT_BYTES)) u_track (
    .clk(clk), .rst(rst), .start(evt.start), .stopped(src_term_q),
    .base_addr(base_addr_i), .accept(accept),
    .buf_addr(buf_addr_o), .buf_size(buf_size_o)
  );

  dma_irq_gen u_irq (
    .clk(clk), .rst(rst), .start(evt.start), .arm(src_term_q),
    .kill(evt.dst_stop), .empty(level == '0), .irq_en(irq_en_i),
    .irq_clr(irq_clr_i), .irq(irq_o), .irq_stat(irq_stat_o)
  );

  a_r4_no_read_after_stop: assert property (@(posedge clk) disable iff (rst)
    src_term_q |-> !(rd_valid_i && rd_ready_o));
  a_r9_discard: assert property (@(posedge clk) disable iff (rst)
    evt.dst_stop |=> !wr_valid_o);
endmodule

// File: tb/dma_term_ctrl_bench.sv
`timescale 1ns/1ps
module dma_term_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic src_active_i = 0, dst_active_i = 0, freeze_i = 0, irq_en_i = 0, irq_clr_i = 0;
  logic [31:0] base_addr_i = '0;
  logic per_req_i = 0, per_done_i = 0, rd_valid_i = 0, wr_ready_i = 0;
  logic [63:0] rd_data_i = '0;
  logic rd_ready_o, wr_valid_o, irq_o, irq_stat_o;
  logic [63:0] wr_data_o;
  logic [15:0] buf_size_o;
  logic [31:0] buf_addr_o;

  int errors = 0, checks = 0, wr_cnt = 0, irq_cnt = 0, seq = 0;
  logic [63:0] exp_q[$];

  always #5 clk = ~clk;

  dma_term_ctrl u_dma_term_ctrl (
    .clk(clk), .rst(rst), .src_active_i(src_active_i), .dst_active_i(dst_active_i),
    .freeze_i(freeze_i), .irq_en_i(irq_en_i), .irq_clr_i(irq_clr_i),
    .base_addr_i(base_addr_i), .per_req_i(per_req_i), .per_done_i(per_done_i),
    .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i), .rd_ready_o(rd_ready_o),
    .wr_valid_o(wr_valid_o), .wr_data_o(wr_data_o), .wr_ready_i(wr_ready_i),
    .buf_size_o(buf_size_o), .buf_addr_o(buf_addr_o), .irq_o(irq_o), .irq_stat_o(irq_stat_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: compares each written beat against the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (wr_valid_o && wr_ready_i) begin
        wr_cnt++;
        if (exp_q.size() == 0) check(0, "R2", "unexpected write", wr_data_o, 0);
        else begin
          check(wr_data_o == exp_q[0], "R2", "write order", wr_data_o, exp_q[0]);
          void'(exp_q.pop_front());
        end
      end
      if (irq_o) begin
        irq_cnt++;
        check(exp_q.size() == 0, "R6", "irq while data owed", exp_q.size(), 0);
      end
    end
  end

  // driver: offers n beats, queues the accepted ones
  task automatic push_beats(input int n, output int acc);
    acc = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      per_req_i = 1; rd_valid_i = 1;
      rd_data_i = {32'hC0DE0000 + 32'(seq), 32'(seq)};
      #1;
      if (rd_ready_o) begin
        exp_q.push_back(rd_data_i);
        acc++; seq++;
      end
    end
    @(negedge clk);
    per_req_i = 0; rd_valid_i = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_done();
    @(negedge clk); per_done_i = 1;
    @(negedge clk); per_done_i = 0;
  endtask

  task automatic restart(input logic [31:0] base);
    @(negedge clk); src_active_i = 0;
    wait_cyc(2);
    base_addr_i = base; src_active_i = 1;
    wait_cyc(2);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int acc, w0, i0;
    logic [63:0] d;
    wait_cyc(3);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(rd_ready_o == 0, "R1", "rd_ready", rd_ready_o, 0);
    check(wr_valid_o == 0, "R1", "wr_valid", wr_valid_o, 0);
    check(irq_o == 0 && irq_stat_o == 0, "R1", "irq", {irq_o, irq_stat_o}, 0);
    check(buf_size_o == 0 && buf_addr_o == 0, "R1", "status", {buf_size_o, buf_addr_o}, 0);

    dst_active_i = 1; wr_ready_i = 1; irq_en_i = 1; base_addr_i = 32'h1000;
    src_active_i = 1;
    wait_cyc(2);

    // R2 streaming
    push_beats(5, acc);
    check(acc == 5, "R2", "accepted", acc, 5);
    wait_cyc(5);
    check(exp_q.size() == 0, "R2", "drained", exp_q.size(), 0);
    check(buf_size_o == 40 && buf_addr_o == 32'h1028, "R2", "status",
          {buf_size_o, buf_addr_o}, {16'd40, 32'h1028});

    // R2 full limit, R10 hold
    wr_ready_i = 0;
    push_beats(15, acc);
    check(acc == 12, "R2", "capacity", acc, 12);
    d = wr_data_o;
    wait_cyc(3);
    check(wr_valid_o && wr_data_o == d && d == exp_q[0], "R10", "held beat", wr_data_o, exp_q[0]);
    wr_ready_i = 1;
    wait_cyc(20);
    check(exp_q.size() == 0, "R2", "full drained", exp_q.size(), 0);

    // R3 freeze
    wr_ready_i = 0;
    push_beats(3, acc);
    @(negedge clk); freeze_i = 1;
    push_beats(2, acc);
    check(acc == 0, "R3", "read while frozen", acc, 0);
    w0 = wr_cnt;
    wr_ready_i = 1;
    wait_cyc(6);
    check(wr_cnt - w0 == 1, "R3", "writes while frozen", wr_cnt - w0, 1);
    check(exp_q.size() == 2, "R3", "kept beats", exp_q.size(), 2);
    freeze_i = 0;
    wait_cyc(10);
    check(exp_q.size() == 0, "R3", "resumed", exp_q.size(), 0);

    // R4/R5/R6/R7 termination by done
    wr_ready_i = 0;
    push_beats(4, acc);
    i0 = irq_cnt;
    pulse_done();
    push_beats(2, acc);
    check(acc == 0, "R4", "read after done", acc, 0);
    check(buf_size_o == 192 && buf_addr_o == 32'h10C0, "R5", "status at stop",
          {buf_size_o, buf_addr_o}, {16'd192, 32'h10C0});
    wr_ready_i = 1;
    wait_cyc(20);
    check(exp_q.size() == 0, "R4", "flushed", exp_q.size(), 0);
    check(irq_cnt - i0 == 1, "R6", "one pulse", irq_cnt - i0, 1);
    check(irq_stat_o == 1, "R7", "sticky set", irq_stat_o, 1);
    check(buf_size_o == 192, "R5", "size held", buf_size_o, 192);
    @(negedge clk); irq_clr_i = 1;
    @(negedge clk); irq_clr_i = 0;
    check(irq_stat_o == 0, "R7", "sticky cleared", irq_stat_o, 0);

    // R11 restart
    restart(32'h2000);
    check(buf_size_o == 0 && buf_addr_o == 32'h2000, "R11", "fresh status",
          {buf_size_o, buf_addr_o}, {16'd0, 32'h2000});
    push_beats(1, acc);
    check(acc == 1, "R11", "accepts again", acc, 1);
    wait_cyc(5);

    // R8 done while frozen
    wr_ready_i = 0;
    push_beats(3, acc);
    i0 = irq_cnt;
    @(negedge clk); freeze_i = 1;
    pulse_done();
    wr_ready_i = 1;
    wait_cyc(10);
    check(exp_q.size() == 0, "R8", "drain under freeze", exp_q.size(), 0);
    check(irq_cnt - i0 == 1, "R8", "irq under freeze", irq_cnt - i0, 1);
    freeze_i = 0;
    @(negedge clk); irq_clr_i = 1;
    @(negedge clk); irq_clr_i = 0;

    // R6/R7 disabled interrupt, stop by clearing source enable
    restart(32'h3000);
    irq_en_i = 0;
    push_beats(2, acc);
    i0 = irq_cnt;
    @(negedge clk); src_active_i = 0;
    wait_cyc(10);
    check(irq_cnt == i0, "R6", "no pulse when disabled", irq_cnt - i0, 0);
    check(irq_stat_o == 0, "R7", "no sticky when disabled", irq_stat_o, 0);
    check(exp_q.size() == 0, "R4", "flush on enable clear", exp_q.size(), 0);
    irq_en_i = 1;

    // R9 destination termination
    restart(32'h4000);
    wr_ready_i = 0;
    push_beats(4, acc);
    i0 = irq_cnt; w0 = wr_cnt;
    @(negedge clk); dst_active_i = 0;
    @(negedge clk);
    check(wr_valid_o == 0, "R9", "valid dropped", wr_valid_o, 0);
    exp_q.delete();
    push_beats(2, acc);
    check(acc == 0, "R9", "read after discard", acc, 0);
    dst_active_i = 1; wr_ready_i = 1;
    wait_cyc(10);
    check(wr_cnt == w0, "R9", "no stale writes", wr_cnt - w0, 0);
    check(irq_cnt == i0, "R9", "no interrupt", irq_cnt - i0, 0);

    restart(32'h5000);
    push_beats(2, acc);
    check(acc == 2, "R11", "restart after discard", acc, 2);
    wait_cyc(6);
    check(exp_q.size() == 0, "R11", "delivered after restart", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule